// File: doc/BRIEF.md
# Pointer-Based Windowed Register File

This block is a general-purpose register file with sixteen 16-bit registers, R0 to R15, that are not built from flip-flops. The registers are words of an on-chip RAM held inside the block. A base pointer register selects where in that RAM the active window of sixteen words starts. Changing the pointer moves the window, so any number of banks can exist, limited only by RAM depth. Because the pointer has word granularity, two windows can share words. A caller can pass parameters by writing its top registers, and a callee whose window starts there sees them as its low registers.

The block has two register read ports and one register write port, each addressed by a 4-bit register number. It also has a direct port that reads and writes the same RAM by byte address, for example for stack or memory traffic. Every read has one cycle of latency. Reads observe writes made in the same cycle.

Top module: `ctx_regbank`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `cp_q`, `rd_a_data`, `rd_b_data` and `mem_rdata` are all zero.
- R2: A register read of number n presented in cycle t returns, after the clock edge ending cycle t, the RAM word at word index (cp_q >> 1) + n.
- R3: A register write of number n stores `wr_data` into RAM word (cp_q >> 1) + n.
- R4: A pointer write loads `cp_wdata` with bit 0 forced to 0. The new value is visible on `cp_q` one cycle later. Without a pointer write, `cp_q` holds its value.
- R5: Register reads and writes issued in the same cycle as a pointer write still use the old pointer. The new pointer applies from the following cycle.
- R6: Word indices wrap modulo the RAM depth (256 words by default). Windows whose pointers differ by less than 32 bytes share words: register k of one window is register k+d of a window 2*d bytes lower.
- R7: The direct port reads RAM word `mem_addr >> 1` with one cycle of latency. Its write stores `mem_wdata` there. It returns the same data as a register read of the same word in the same cycle.
- R8: A read of any port to a word that is written in the same cycle returns the newly written data.
- R9: If the register write port and the direct write port hit the same word in the same cycle, the register write data is stored and forwarded.
- R10: The two register read ports are independent; each returns its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_we | input | 1 | Load the base pointer |
| cp_wdata | input | 9 | New base pointer byte address |
| cp_q | output | 9 | Current base pointer |
| rd_a_num | input | 4 | Register number, read port A |
| rd_a_data | output | 16 | Read data, port A (registered) |
| rd_b_num | input | 4 | Register number, read port B |
| rd_b_data | output | 16 | Read data, port B (registered) |
| wr_en | input | 1 | Register write enable |
| wr_num | input | 4 | Register number for write |
| wr_data | input | 16 | Register write data |
| mem_we | input | 1 | Direct write enable |
| mem_addr | input | 9 | Direct byte address (bit 0 ignored) |
| mem_wdata | input | 16 | Direct write data |
| mem_rdata | output | 16 | Direct read data (registered) |

## Verification
A corrupted base pointer shows up one cycle after the pointer write, either on `cp_q` or as a whole window of register reads that are shifted or wrapped incorrectly. A fault in the address adder or the forwarding path shows up on the very next read as data that does not match what the direct port returns for the same word. The sweeps compare every register of several windows against words written through the direct port. These windows include one that wraps past the top of RAM and one made from an odd pointer. Each mismatch is therefore visible one cycle after the access that caused it.

// File: rtl/ctx_regbank_pkg.sv
package ctx_regbank_pkg;
  // Read ports of the storage array, in port-index order.
  typedef enum int {
    RP_REG_A  = 0,
    RP_REG_B  = 1,
    RP_DIRECT = 2
  } rd_port_e;
  localparam int RD_PORTS = 3;
endpackage

// File: rtl/ctx_pointer_reg.sv
module ctx_pointer_reg #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] cp
);
  // Word alignment: bit 0 is never stored as 1.
  always_ff @(posedge clk) begin
    if (rst)     cp <= '0;
    else if (we) cp <= {wdata[ADDR_W-1:1], 1'b0};
  end
endmodule

// File: rtl/ctx_addr_xlate.sv
module ctx_addr_xlate #(
  parameter int ADDR_W = 9,
  parameter int NUM_W  = 4,
  localparam int WORD_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] cp,
  input  logic [NUM_W-1:0]  num,
  output logic [WORD_W-1:0] word
);
  // Byte address cp + 2*n maps to word cp/2 + n; overflow wraps.
  always_comb word = cp[ADDR_W-1:1] + WORD_W'(num);
endmodule

// File: rtl/ctx_ram.sv
module ctx_ram #(
  parameter int DATA_W = 16,
  parameter int WORD_W = 8,
  parameter int NRD    = 3,
  localparam int DEPTH = 1 << WORD_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         hi_we,
  input  logic [WORD_W-1:0]            hi_addr,
  input  logic [DATA_W-1:0]            hi_data,
  input  logic                         lo_we,
  input  logic [WORD_W-1:0]            lo_addr,
  input  logic [DATA_W-1:0]            lo_data,
  input  logic [NRD-1:0][WORD_W-1:0]   rd_addr,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // The high-priority write is applied last, so it wins a collision.
  always_ff @(posedge clk) begin
    if (lo_we) mem[lo_addr] <= lo_data;
    if (hi_we) mem[hi_addr] <= hi_data;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                              q <= '0;
      else if (hi_we && hi_addr == rd_addr[i]) q <= hi_data;
      else if (lo_we && lo_addr == rd_addr[i]) q <= lo_data;
      else                                  q <= mem[rd_addr[i]];
    end
    assign rd_data[i] = q;
  end
endmodule

// File: rtl/ctx_regbank.sv
module ctx_regbank
  import ctx_regbank_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 9,
  parameter int NUM_REGS = 16,
  localparam int NUM_W   = $clog2(NUM_REGS),
  localparam int WORD_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cp_we,
  input  logic [ADDR_W-1:0] cp_wdata,
  output logic [ADDR_W-1:0] cp_q,
  input  logic [NUM_W-1:0]  rd_a_num,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [NUM_W-1:0]  rd_b_num,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [NUM_W-1:0]  wr_num,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata
);
  localparam int NXL = 3; // translators: read A, read B, write

  logic [ADDR_W-1:0]                 cp;
  logic [NXL-1:0][NUM_W-1:0]         xl_num;
  logic [NXL-1:0][WORD_W-1:0]        xl_word;
  logic [RD_PORTS-1:0][WORD_W-1:0]   ram_raddr;
  logic [RD_PORTS-1:0][DATA_W-1:0]   ram_rdata;

  ctx_pointer_reg #(.ADDR_W(ADDR_W)) u_cp (
    .clk(clk), .rst(rst), .we(cp_we), .wdata(cp_wdata), .cp(cp)
  );

  assign xl_num[0] = rd_a_num;
  assign xl_num[1] = rd_b_num;
  assign xl_num[2] = wr_num;

  for (genvar k = 0; k < NXL; k++) begin : g_xl
    ctx_addr_xlate #(.ADDR_W(ADDR_W), .NUM_W(NUM_W)) u_xl (
      .cp(cp), .num(xl_num[k]), .word(xl_word[k])
    );
  end

  assign ram_raddr[RP_REG_A]  = xl_word[0];
  assign ram_raddr[RP_REG_B]  = xl_word[1];
  assign ram_raddr[RP_DIRECT] = mem_addr[ADDR_W-1:1];

  ctx_ram #(.DATA_W(DATA_W), .WORD_W(WORD_W), .NRD(RD_PORTS)) u_ram (
    .clk(clk), .rst(rst),
    .hi_we(wr_en),  .hi_addr(xl_word[2]),          .hi_data(wr_data),
    .lo_we(mem_we), .lo_addr(mem_addr[ADDR_W-1:1]), .lo_data(mem_wdata),
    .rd_addr(ram_raddr), .rd_data(ram_rdata)
  );

  assign cp_q      = cp;
  assign rd_a_data = ram_rdata[RP_REG_A];
  assign rd_b_data = ram_rdata[RP_REG_B];
  assign mem_rdata = ram_rdata[RP_DIRECT];
endmodule

// File: rtl/ctx_regbank_chk.sv
module ctx_regbank_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 9,
  parameter int NUM_W  = 4,
  localparam int WORD_W = ADDR_W - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cp_we,
  input logic [ADDR_W-1:0] cp_wdata,
  input logic [ADDR_W-1:0] cp_q,
  input logic [NUM_W-1:0]  rd_a_num,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [NUM_W-1:0]  wr_num,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_rdata
);
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cp_q == '0 && rd_a_data == '0 && rd_b_data == '0 && mem_rdata == '0));

  a_r4_cp_even: assert property (@(posedge clk) disable iff (rst)
    cp_q[0] == 1'b0);

  a_r4_cp_load: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cp_we)) |-> cp_q == {$past(cp_wdata[ADDR_W-1:1]), 1'b0});

  a_r5_cp_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cp_we)) |-> $stable(cp_q));

  a_r8_bypass_a: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && wr_num == rd_a_num)) |-> rd_a_data == $past(wr_data));

  a_r7_direct_match: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mem_addr[ADDR_W-1:1] == WORD_W'(cp_q[ADDR_W-1:1] + WORD_W'(rd_a_num))))
      |-> mem_rdata == rd_a_data);
endmodule

bind ctx_regbank ctx_regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_W(NUM_W)) u_chk (
  .clk(clk), .rst(rst), .cp_we(cp_we), .cp_wdata(cp_wdata), .cp_q(cp_q),
  .rd_a_num(rd_a_num), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
  .mem_addr(mem_addr), .mem_rdata(mem_rdata)
);

// File: tb/tb_ctx_regbank.sv
module tb_ctx_regbank;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 9;
  localparam int NUM_W  = 4;
  localparam int WORDS  = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cp_we = 1'b0;
  logic [ADDR_W-1:0] cp_wdata = '0;
  logic [ADDR_W-1:0] cp_q;
  logic [NUM_W-1:0] rd_a_num = '0, rd_b_num = '0, wr_num = '0;
  logic [DATA_W-1:0] rd_a_data, rd_b_data, mem_rdata;
  logic wr_en = 1'b0, mem_we = 1'b0;
  logic [DATA_W-1:0] wr_data = '0, mem_wdata = '0;
  logic [ADDR_W-1:0] mem_addr = '0;

  logic [DATA_W-1:0] model [WORDS];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ctx_regbank dut (
    .clk(clk), .rst(rst), .cp_we(cp_we), .cp_wdata(cp_wdata), .cp_q(cp_q),
    .rd_a_num(rd_a_num), .rd_a_data(rd_a_data), .rd_b_num(rd_b_num), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] widx(input logic [ADDR_W-1:0] cp, input int n);
    return 8'((cp >> 1) + n);
  endfunction

  task automatic set_cp(input logic [ADDR_W-1:0] v);
    cp_we = 1'b1; cp_wdata = v;
    @(negedge clk);
    cp_we = 1'b0;
    chk("R4 pointer load", 32'(cp_q), 32'(v & ~9'd1));
  endtask

  task automatic sweep_read(input logic [ADDR_W-1:0] cp);
    for (int n = 0; n < 16; n++) begin
      rd_a_num = 4'(n); rd_b_num = 4'(15 - n);
      mem_addr = {widx(cp, n), 1'b0};
      @(negedge clk);
      chk("R2/R6 read A", 32'(rd_a_data), 32'(model[widx(cp, n)]));
      chk("R10 read B",   32'(rd_b_data), 32'(model[widx(cp, 15 - n)]));
      chk("R7 direct vs register", 32'(mem_rdata), 32'(rd_a_data));
    end
  endtask

  task automatic direct_check(input logic [7:0] w, input string req);
    mem_addr = {w, 1'b0};
    @(negedge clk);
    chk(req, 32'(mem_rdata), 32'(model[w]));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [ADDR_W-1:0] c1;
    logic [ADDR_W-1:0] c2;
    logic [7:0] w;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 cp_q", 32'(cp_q), 0);
    chk("R1 rd_a", 32'(rd_a_data), 0);
    chk("R1 rd_b", 32'(rd_b_data), 0);
    chk("R1 mem_rdata", 32'(mem_rdata), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", 32'(cp_q), 0);

    // R7: fill every word through the direct port (odd byte addresses on half)
    for (int i = 0; i < WORDS; i++) begin
      model[i] = 16'(i * 16'h0123 + 16'h4321);
      mem_we = 1'b1; mem_addr = {8'(i), 1'(i & 1)}; mem_wdata = model[i];
      @(negedge clk);
    end
    mem_we = 1'b0;
    for (int i = 0; i < WORDS; i++) direct_check(8'(i), "R7 direct readback");

    // R2 R4 R6 R10: windows including odd pointer and top-of-RAM wrap
    set_cp(9'h000); sweep_read(9'h000);
    set_cp(9'h020); sweep_read(9'h020);
    set_cp(9'h0A3); sweep_read(9'h0A2);
    set_cp(9'h1F4); sweep_read(9'h1F4);

    // R3 R6: register writes in the wrapping window
    for (int n = 0; n < 16; n++) begin
      wr_en = 1'b1; wr_num = 4'(n); wr_data = 16'(16'hC000 + n * 16'h0111);
      model[widx(9'h1F4, n)] = wr_data;
      @(negedge clk);
    end
    wr_en = 1'b0;
    for (int n = 0; n < 16; n++) direct_check(widx(9'h1F4, n), "R3 register write stored");

    // R5: pointer write in the same cycle as a read and a write
    c1 = 9'h1F4; c2 = 9'h040;
    cp_we = 1'b1; cp_wdata = c2; rd_a_num = 4'd3;
    wr_en = 1'b1; wr_num = 4'd4; wr_data = 16'hBEEF;
    model[widx(c1, 4)] = 16'hBEEF;
    @(negedge clk);
    cp_we = 1'b0; wr_en = 1'b0;
    chk("R5 read uses old pointer", 32'(rd_a_data), 32'(model[widx(c1, 3)]));
    @(negedge clk);
    chk("R5 read uses new pointer", 32'(rd_a_data), 32'(model[widx(c2, 3)]));
    direct_check(widx(c1, 4), "R5 write uses old pointer");
    direct_check(widx(c2, 4), "R5 new bank word untouched");

    // R6: overlap, R8 of window 0x040 is R0 of window 0x050
    wr_en = 1'b1; wr_num = 4'd8; wr_data = 16'h1357;
    model[widx(c2, 8)] = 16'h1357;
    @(negedge clk);
    wr_en = 1'b0;
    set_cp(9'h050);
    rd_a_num = 4'd0; rd_b_num = 4'd15;
    @(negedge clk);
    chk("R6 overlapping windows", 32'(rd_a_data), 32'h1357);

    // R8: same-cycle write and reads of the same word on all ports
    wr_en = 1'b1; wr_num = 4'd5; wr_data = 16'hA5A5;
    rd_a_num = 4'd5; rd_b_num = 4'd5; mem_addr = {widx(9'h050, 5), 1'b0};
    model[widx(9'h050, 5)] = 16'hA5A5;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 bypass A", 32'(rd_a_data), 32'hA5A5);
    chk("R8 bypass B", 32'(rd_b_data), 32'hA5A5);
    chk("R8 bypass direct", 32'(mem_rdata), 32'hA5A5);
    // R8: direct write forwarded to a register read
    mem_we = 1'b1; mem_addr = {widx(9'h050, 6), 1'b0}; mem_wdata = 16'h6666;
    rd_a_num = 4'd6;
    model[widx(9'h050, 6)] = 16'h6666;
    @(negedge clk);
    mem_we = 1'b0;
    chk("R8 direct write to register read", 32'(rd_a_data), 32'h6666);

    // R9: both write ports on one word
    w = widx(9'h050, 7);
    wr_en = 1'b1; wr_num = 4'd7; wr_data = 16'h7A7A;
    mem_we = 1'b1; mem_addr = {w, 1'b0}; mem_wdata = 16'h0B0B;
    rd_a_num = 4'd7;
    model[w] = 16'h7A7A;
    @(negedge clk);
    wr_en = 1'b0; mem_we = 1'b0;
    chk("R9 forwarded winner", 32'(rd_a_data), 32'h7A7A);
    @(negedge clk);
    chk("R9 stored winner", 32'(rd_a_data), 32'h7A7A);
    direct_check(w, "R9 stored winner direct");

    finish_run();
  end
endmodule